// File: doc/BRIEF.md
# Double-buffered raster timing generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display, along with a pixel position counter and a line counter, all in the pixel clock domain. Each line and each frame is laid out in this fixed order: sync pulse, back porch, active region, front porch. Software sets the length of each phase through four 32-bit timing words written on a plain register write port.

Timing words land in a shadow set that the counters do not see. A separate arm command requests that the shadow set be copied into the working set. The copy happens on the last pixel of the current frame, so the next frame is the first to run with the new values. A frame never mixes old and new timing. Every length of zero is treated as one, so no counter can degenerate.

Every pin is control or status, so there is no valid/ready handshake. The write port takes one word in any cycle where `wr_en` is high and never stalls. The timing outputs run freely and the receiver cannot push back on them. The block does not check pixel-rate limits; keeping programmed totals within the link's rate budget is up to the caller.

Top module: `scan_timing_gen`

## Requirements
- R1: During and right after reset, both counters are 0 and no arm command is pending. The working set and the shadow set both hold the parameter defaults (sync 2, back 3, active 8, front 2 pixels; sync 1, back 2, active 4, front 1 lines).
- R2: `pix_x` advances by one on every clock from 0 to htotal-1 and then returns to 0, where htotal is the sum of the four horizontal lengths. `line_y` advances by one each time `pix_x` wraps and runs from 0 to vtotal-1.
- R3: `hsync` is high exactly while `pix_x` is below the horizontal sync width.
- R4: `vsync` is high exactly while `line_y` is below the vertical sync width, so it can change only where `pix_x` is 0.
- R5: `de` is high exactly when both counters are in their active windows. The horizontal window is sync+back <= `pix_x` < sync+back+active, and the vertical window is defined the same way on `line_y`.
- R6: The write addresses for the shadow words are as follows. Address 0 holds the horizontal back porch in bits 31:16 and the horizontal sync width in bits 15:0. Address 1 holds the horizontal front porch in bits 31:16 and the active pixel count in bits 15:0. Addresses 2 and 3 hold the same two layouts for lines. A shadow write has no effect on the outputs until a transfer takes place.
- R7: A write to address 4 with bit 0 = 1 arms a transfer. On the clock edge where `pix_x` = htotal-1 and `line_y` = vtotal-1, an armed transfer copies the shadow set into the working set and the arm clears itself. A write to address 4 with bit 0 = 0 does nothing.
- R8: Any length programmed as 0 behaves as a length of 1.
- R9: Writes to addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, active high |
| pix_x | output | 18 | Pixel position within the line, 0 at first sync pixel |
| line_y | output | 18 | Line position within the frame, 0 at first sync line |

## Verification
The bench runs the default timing and then a swept family of small configurations. The sweep mixes unequal sync, porch and active lengths, and some configurations include zeros. This separates errors in phase ordering, off-by-one window edges and the zero clamp, and a bench model predicts every output on every cycle. Each swept configuration is written to the shadow set while a frame is running and left unarmed for a while. It is then followed by an arm write with bit 0 clear and a write to an unused address. Holding the old timing through these steps separates a correct shadow set from one that leaks writes early. The final real arm shows whether the transfer lands exactly at the frame boundary and not mid-frame.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
  localparam int FLD_W  = 16;
  localparam int DATA_W = 2 * FLD_W;
  localparam int POS_W  = FLD_W + 2;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic [FLD_W-1:0] sync;
    logic [FLD_W-1:0] back;
    logic [FLD_W-1:0] act;
    logic [FLD_W-1:0] front;
  } axis_cfg_t;

  localparam logic [ADDR_W-1:0] ADR_H_LEAD = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_H_TAIL = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_V_LEAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_V_TAIL = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ARM    = 3'd4;

  function automatic logic [FLD_W-1:0] at_least_one(input logic [FLD_W-1:0] v);
    return (v == '0) ? FLD_W'(1) : v;
  endfunction
endpackage

// File: rtl/stg_regs.sv
module stg_regs
  import scan_timing_pkg::*;
#(
  parameter axis_cfg_t RST_H = '0,
  parameter axis_cfg_t RST_V = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_end,
  output axis_cfg_t         act_h,
  output axis_cfg_t         act_v
);
  axis_cfg_t shd_q [2];
  axis_cfg_t act_q [2];
  logic      armed_q;
  logic      arm_req;
  logic      xfer;

  assign arm_req = wr_en && (wr_addr == ADR_ARM) && wr_data[0];
  assign xfer    = frame_end && armed_q;

  // arm is consumed at the boundary; a new request in the same cycle re-arms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= (armed_q && !frame_end) || arm_req;
  end

  for (genvar g = 0; g < 2; g++) begin : g_axis
    localparam axis_cfg_t RST_G = (g == 0) ? RST_H : RST_V;
    localparam logic [ADDR_W-1:0] LEAD_A = ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] TAIL_A = ADDR_W'(2 * g + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q[g] <= RST_G;
      end else if (wr_en && wr_addr == LEAD_A) begin
        shd_q[g].back <= wr_data[DATA_W-1:FLD_W];
        shd_q[g].sync <= wr_data[FLD_W-1:0];
      end else if (wr_en && wr_addr == TAIL_A) begin
        shd_q[g].front <= wr_data[DATA_W-1:FLD_W];
        shd_q[g].act   <= wr_data[FLD_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_q[g] <= RST_G;
      else if (xfer) act_q[g] <= shd_q[g];
    end
  end

  assign act_h = act_q[0];
  assign act_v = act_q[1];
endmodule

// File: rtl/stg_axis.sv
module stg_axis
  import scan_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  axis_cfg_t        cfg,
  output logic [POS_W-1:0] pos,
  output logic             last,
  output logic             in_sync,
  output logic             in_act
);
  logic [POS_W-1:0] len_s, len_b, len_a, len_f;
  logic [POS_W-1:0] act_start, act_stop, total;

  always_comb begin
    len_s     = POS_W'(at_least_one(cfg.sync));
    len_b     = POS_W'(at_least_one(cfg.back));
    len_a     = POS_W'(at_least_one(cfg.act));
    len_f     = POS_W'(at_least_one(cfg.front));
    act_start = len_s + len_b;
    act_stop  = act_start + len_a;
    total     = act_stop + len_f;
  end

  assign last    = (pos == total - POS_W'(1));
  assign in_sync = (pos < len_s);
  assign in_act  = (pos >= act_start) && (pos < act_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos <= '0;
    else if (adv) pos <= last ? '0 : pos + POS_W'(1);
  end
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
#(
  parameter int H_SYNC  = 2,
  parameter int H_BACK  = 3,
  parameter int H_ACT   = 8,
  parameter int H_FRONT = 2,
  parameter int V_SYNC  = 1,
  parameter int V_BACK  = 2,
  parameter int V_ACT   = 4,
  parameter int V_FRONT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [POS_W-1:0]  pix_x,
  output logic [POS_W-1:0]  line_y
);
  localparam axis_cfg_t H_RST = '{sync: FLD_W'(H_SYNC), back: FLD_W'(H_BACK),
                                  act: FLD_W'(H_ACT), front: FLD_W'(H_FRONT)};
  localparam axis_cfg_t V_RST = '{sync: FLD_W'(V_SYNC), back: FLD_W'(V_BACK),
                                  act: FLD_W'(V_ACT), front: FLD_W'(V_FRONT)};

  axis_cfg_t act_h, act_v;
  logic h_last, v_last, h_sync, v_sync, h_act, v_act;
  logic frame_end;

  assign frame_end = h_last && v_last;

  stg_regs #(.RST_H(H_RST), .RST_V(V_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_end(frame_end), .act_h(act_h), .act_v(act_v)
  );

  stg_axis u_h (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .cfg(act_h),
    .pos(pix_x), .last(h_last), .in_sync(h_sync), .in_act(h_act)
  );

  stg_axis u_v (
    .clk(clk), .rst_n(rst_n), .adv(h_last), .cfg(act_v),
    .pos(line_y), .last(v_last), .in_sync(v_sync), .in_act(v_act)
  );

  assign hsync = h_sync;
  assign vsync = v_sync;
  assign de    = h_act && v_act;
endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk
  import scan_timing_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [POS_W-1:0] pix_x,
  input logic [POS_W-1:0] line_y,
  input axis_cfg_t        act_h,
  input axis_cfg_t        act_v
);
  // R2
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> (pix_x == $past(pix_x) + POS_W'(1)));

  // R2
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> $stable(line_y));

  // R4
  vs_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> (pix_x == '0));

  // R5
  de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  // R7
  xfer_at_frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_h) || !$stable(act_v)) |-> (pix_x == '0 && line_y == '0));
endmodule

bind scan_timing_gen scan_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de),
  .pix_x(pix_x), .line_y(line_y), .act_h(act_h), .act_v(act_v)
);

// File: tb/scan_timing_gen_test.sv
`timescale 1ns/1ps
module scan_timing_gen_test;
  import scan_timing_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic hsync, vsync, de;
  logic [POS_W-1:0] pix_x, line_y;

  always #2.5 clk = ~clk;

  scan_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .line_y(line_y)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R2";

  // model state: [0]=horizontal [1]=vertical; lengths sync, back, act, front
  int act_m [2][4];
  int shd_m [2][4];
  bit armed_m;
  int mx, my;

  task automatic chk(input string tag, input int a, input int e);
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, a, e);
    end
  endtask

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int tot(input int ax);
    return nz(act_m[ax][0]) + nz(act_m[ax][1]) + nz(act_m[ax][2]) + nz(act_m[ax][3]);
  endfunction

  function automatic bit in_act(input int ax, input int p);
    int st = nz(act_m[ax][0]) + nz(act_m[ax][1]);
    return (p >= st) && (p < st + nz(act_m[ax][2]));
  endfunction

  task automatic compare();
    chk({phase, " R2 pix_x"}, int'(pix_x), mx);
    chk({phase, " R2 line_y"}, int'(line_y), my);
    chk({phase, " R3 hsync"}, int'(hsync), int'(mx < nz(act_m[0][0])));
    chk({phase, " R4 vsync"}, int'(vsync), int'(my < nz(act_m[1][0])));
    chk({phase, " R5 de"}, int'(de), int'(in_act(0, mx) && in_act(1, my)));
  endtask

  // called at a negedge; models the next posedge then compares after it
  task automatic tick(input bit we, input int adr, input logic [31:0] d);
    bit fe;
    wr_en = we; wr_addr = ADDR_W'(adr); wr_data = d;
    fe = (mx == tot(0) - 1) && (my == tot(1) - 1);
    if (fe) begin
      if (armed_m) act_m = shd_m;
      armed_m = 0;
      mx = 0; my = 0;
    end else if (mx == tot(0) - 1) begin
      mx = 0; my++;
    end else begin
      mx++;
    end
    if (we) begin
      if (adr == 0) begin shd_m[0][1] = int'(d[31:16]); shd_m[0][0] = int'(d[15:0]); end
      if (adr == 1) begin shd_m[0][3] = int'(d[31:16]); shd_m[0][2] = int'(d[15:0]); end
      if (adr == 2) begin shd_m[1][1] = int'(d[31:16]); shd_m[1][0] = int'(d[15:0]); end
      if (adr == 3) begin shd_m[1][3] = int'(d[31:16]); shd_m[1][2] = int'(d[15:0]); end
      if (adr == 4 && d[0]) armed_m = 1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic program_cfg(input int hs, hb, ha, hf, vs, vb, va, vf);
    tick(1, 0, {16'(hb), 16'(hs)});
    tick(1, 1, {16'(hf), 16'(ha)});
    tick(1, 2, {16'(vb), 16'(vs)});
    tick(1, 3, {16'(vf), 16'(va)});
  endtask

  initial begin
    act_m[0] = '{2, 3, 8, 2};
    act_m[1] = '{1, 2, 4, 1};
    shd_m = act_m;
    armed_m = 0; mx = 0; my = 0;
    repeat (3) @(negedge clk);
    phase = "R1";
    chk("R1 pix_x in reset", int'(pix_x), 0);
    chk("R1 line_y in reset", int'(line_y), 0);
    chk("R1 hsync in reset", int'(hsync), 1);
    chk("R1 vsync in reset", int'(vsync), 1);
    chk("R1 de in reset", int'(de), 0);
    rst_n = 1'b1;
    run(240);

    for (int k = 0; k < 6; k++) begin
      int hs = k % 3 + 1, hb = (k + 1) % 3, ha = k + 2, hf = (2 * k) % 4;
      int vs = (k + 2) % 3, vb = k % 2 + 1, va = (k % 3) + 1, vf = (k + 1) % 2;
      phase = "R6";
      program_cfg(hs, hb, ha, hf, vs, vb, va, vf);
      run(150);
      phase = "R7";
      tick(1, 4, 32'hFFFF_FFFE);
      run(150);
      phase = "R9";
      tick(1, 5, 32'h0001_0001);
      tick(1, 7, 32'hFFFF_FFFF);
      run(20);
      phase = "R7";
      tick(1, 4, 32'h1);
      run(300);
    end

    phase = "R8";
    program_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    tick(1, 4, 32'h1);
    run(400);
    begin
      int ones = 0, des = 0;
      for (int i = 0; i < 16; i++) begin
        tick(0, 0, 0);
        ones += int'(hsync);
        des  += int'(de);
      end
      chk("R8 hsync cycles in 16 with zero lengths", ones, 4);
      chk("R8 de cycles per 4x4 frame", des, 1);
    end

    phase = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pix_x after second reset", int'(pix_x), 0);
    chk("R1 hsync width default after reset", int'(hsync), 1);
    act_m[0] = '{2, 3, 8, 2};
    act_m[1] = '{1, 2, 4, 1};
    shd_m = act_m;
    armed_m = 0; mx = 0; my = 0;
    rst_n = 1'b1;
    run(130);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule